// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives clause-22 management transactions on an MDC/MDIO pair so that a host can read and write PHY registers. The host writes one 32-bit command word. The block latches it, builds the serial frame and shifts it out. On a read it also captures the 16 bits that the PHY returns. The MDIO pad is modelled as three signals: a driven value, an output enable and the sampled pad input. A board-level tri-state buffer combines them.

The MDC period is the system clock divided by 8, 16, 32 or 64. Software chooses the ratio that keeps MDC at or below 2.5 MHz:
- 64 for clocks above 80 MHz
- 32 above 40 MHz
- 16 above 20 MHz
- 8 otherwise

The block only works while a management enable input is high. Dropping that input stops MDC and abandons any frame in flight. An idle flag is low for the whole of a transaction. Software polls it before it reads back the command/data word.

Command word layout:
- bit 29: read (1) or write (0)
- bits 27:23: PHY address
- bits 22:18: register address
- bits 15:0: write data

The remaining bits are stored and read back but do not shape the frame.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, status_idle is 1, mdc is 0, mdio_oe is 0, mdio_out is 0 and data_word is zero.
- R2: While a frame runs, MDC has a period of 8, 16, 32 or 64 system clocks for div_sel 0, 1, 2 or 3, with half of the period low and half high. The ratio is taken when the command is accepted, so changing div_sel mid-frame has no effect on that frame.
- R3: A command is accepted on a clock edge where cmd_wr and mgmt_en are high and status_idle is high. Acceptance copies cmd_word into data_word. A cmd_wr while busy is ignored: data_word and the frame in progress are unchanged.
- R4: status_idle goes low at the accepting edge. It returns high on the edge where MDC falls at the end of the 64th MDC cycle. While idle, mdc and mdio_oe are 0.
- R5: The frame is 64 MDC cycles long, each bit sent MSB first:
  - 32 ones
  - start 01
  - opcode 10 for a read or 01 for a write
  - 5-bit PHY address
  - 5-bit register address
  - a 2-bit turnaround
  - 16 data bits

  The start, opcode and turnaround bits are generated by the block and do not depend on cmd_word bits 31:30, 28 or 17:16.
- R6: On a write, mdio_oe stays high for all 64 cycles, the turnaround is driven as 10 and the data field carries cmd_word bits 15:0.
- R7: On a read, mdio_oe is high for cycles 0 to 45 and low from cycle 46 (the turnaround) to the end of the frame.
- R8: mdio_out changes only on the clock edge where mdc falls, or at command acceptance.
- R9: On a read, mdio_in is sampled on each MDC rising edge of cycles 48 to 63, first sample as bit 15. At frame end these 16 bits replace data_word bits 15:0, and bits 31:16 keep the written value.
- R10: If mgmt_en is low on a clock edge while a frame runs, the frame is abandoned at that edge: mdc and mdio_oe go to 0, status_idle goes to 1, and data_word keeps the command as written.
- R11: cmd_wr while mgmt_en is low is ignored: no frame starts and data_word is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC ratio select: 0=8, 1=16, 2=32, 3=64 |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| status_idle | output | 1 | High when no frame is in progress |
| data_word | output | 32 | Stored command; low half holds read data after a read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | Sampled MDIO pad value |

## Verification
The bench goes after the edges of the frame:
- The turnaround release on reads: a design one cycle late would collide with the PHY on the bus.
- The first and last captured data bits: an off-by-one would shift the returned value or drop bit 0.
- A command written while busy: a wrong design would overwrite data_word or restart the frame.
- A ratio change mid-frame: an unlatched divider would bend the MDC period.
- Junk in the start, opcode and turnaround positions of cmd_word: a design that copies them through would put an invalid frame on the wire.
- Enable dropping mid-frame, followed by a command with enable low: a design that let either through would leave MDC toggling or start an unwanted transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int BODY_W   = 32;
  localparam int DATA_W   = 16;
  localparam int FLD_RD   = 29;
  localparam int PHY_HI   = 27;
  localparam int PHY_LO   = 23;
  localparam int REGA_HI  = 22;
  localparam int REGA_LO  = 18;

  // Frame body after the preamble: start, opcode, addresses, turnaround, data.
  function automatic logic [BODY_W-1:0] cl22_body(
    input logic              is_rd,
    input logic [4:0]        phy,
    input logic [4:0]        rega,
    input logic [DATA_W-1:0] wdata
  );
    logic [1:0] opc;
    logic [1:0] ta;
    logic [DATA_W-1:0] dfld;
    opc  = is_rd ? 2'b10 : 2'b01;
    ta   = is_rd ? 2'b00 : 2'b10;
    dfld = is_rd ? '0 : wdata;
    return {2'b01, opc, phy, rega, ta, dfld};
  endfunction

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int BASE_DIV = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_cnt;

  always_comb begin
    last_cnt = CNT_W'((BASE_DIV << sel) - 1);
    half_cnt = CNT_W'(((BASE_DIV << sel) / 2) - 1);
  end

  assign rise_stb = run && (cnt == half_cnt);
  assign fall_stb = run && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_stb ? '0 : cnt + 1'b1;
      if (rise_stb) begin
        mdc <= 1'b1;
      end else if (fall_stb) begin
        mdc <= 1'b0;
      end
    end
  end

  // R10: a stopped divider holds MDC low
  assert_stop_low_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);

  // R2: phase counter never passes the selected ratio
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_cnt);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              en,
  input  logic              is_rd,
  input  logic [4:0]        phy,
  input  logic [4:0]        rega,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_in,
  output logic              busy,
  output logic              rd_q,
  output logic              fin,
  output logic [DATA_W-1:0] cap,
  output logic              mdio_out,
  output logic              mdio_oe
);

  localparam int FRAME_W  = PRE_LEN + BODY_W;
  localparam int BIT_W    = $clog2(FRAME_W);
  localparam int TA_BIT   = PRE_LEN + 14;
  localparam int DATA_BIT = PRE_LEN + 16;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] PRE_TA   = BIT_W'(TA_BIT - 1);
  localparam logic [BIT_W-1:0] FIRST_RX = BIT_W'(DATA_BIT);

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] shreg;
  logic [BIT_W-1:0]   bit_idx;

  assign frame = {{PRE_LEN{1'b1}}, cl22_body(is_rd, phy, rega, wdata)};
  assign fin   = busy && fall_stb && (bit_idx == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rd_q     <= 1'b0;
      bit_idx  <= '0;
      shreg    <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      rd_q     <= is_rd;
      bit_idx  <= '0;
      shreg    <= frame << 1;
      mdio_out <= frame[FRAME_W-1];
      mdio_oe  <= 1'b1;
    end else if (busy && !en) begin
      busy     <= 1'b0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (fall_stb) begin
      if (bit_idx == LAST_BIT) begin
        busy     <= 1'b0;
        mdio_out <= 1'b0;
        mdio_oe  <= 1'b0;
      end else begin
        bit_idx  <= bit_idx + 1'b1;
        mdio_out <= shreg[FRAME_W-1];
        shreg    <= shreg << 1;
        mdio_oe  <= !(rd_q && (bit_idx >= PRE_TA));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
    end else if (busy && rise_stb && rd_q && (bit_idx >= FIRST_RX)) begin
      cap <= {cap[DATA_W-2:0], mdio_in};
    end
  end

  // R6: a write frame keeps the pad driven
  assert_write_drives_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_q) |-> mdio_oe);

  // R7: no capture happens while the master still drives the pad
  assert_rx_released_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && rise_stb && (bit_idx >= FIRST_RX)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int BASE_DIV = 8,
  parameter int SEL_W    = 2,
  parameter int PRE_LEN  = 32,
  parameter int CMD_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mgmt_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             status_idle,
  output logic [CMD_W-1:0] data_word,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe,
  input  logic             mdio_in
);

  logic             busy;
  logic             rd_q;
  logic             fin;
  logic             accept;
  logic             run;
  logic             rise_stb;
  logic             fall_stb;
  logic [SEL_W-1:0] sel_q;
  logic [DATA_W-1:0] cap;

  assign accept      = cmd_wr && mgmt_en && !busy;
  assign run         = busy && mgmt_en;
  assign status_idle = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      data_word <= '0;
    end else if (accept) begin
      sel_q     <= div_sel;
      data_word <= cmd_word;
    end else if (fin && rd_q) begin
      data_word[DATA_W-1:0] <= cap;
    end
  end

  mdio_mdc_div #(
    .BASE_DIV (BASE_DIV),
    .SEL_W    (SEL_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .restart  (accept),
    .sel      (sel_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .en       (mgmt_en),
    .is_rd    (cmd_word[FLD_RD]),
    .phy      (cmd_word[PHY_HI:PHY_LO]),
    .rega     (cmd_word[REGA_HI:REGA_LO]),
    .wdata    (cmd_word[DATA_W-1:0]),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_in  (mdio_in),
    .busy     (busy),
    .rd_q     (rd_q),
    .fin      (fin),
    .cap      (cap),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  // R3: a command arriving mid-frame leaves the stored word alone
  assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr && !fin) |=> $stable(data_word));

  // R4: an idle port is silent
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    status_idle |-> (!mdc && !mdio_oe));

  // R8: the driven bit moves only with a falling MDC
  assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_out)) |-> $fell(mdc));

  // R11: with enable low, an idle port stays idle
  assert_en_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (!mgmt_en && status_idle) |=> status_idle);

endmodule

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mgmt_en = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        status_idle;
  logic [31:0] data_word;
  logic        mdc;
  logic        mdio_out;
  logic        mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_busy = 0;
  int          m_t = 0;
  int          m_n = 8;
  int          m_rd = 0;
  logic [31:0] m_data = '0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_cap = '0;
  logic [15:0] resp = '0;

  always #10 clk = ~clk;

  mdio_frame_master uut (
    .clk         (clk),
    .rst         (rst),
    .mgmt_en     (mgmt_en),
    .div_sel     (div_sel),
    .cmd_wr      (cmd_wr),
    .cmd_word    (cmd_word),
    .status_idle (status_idle),
    .data_word   (data_word),
    .mdc         (mdc),
    .mdio_out    (mdio_out),
    .mdio_oe     (mdio_oe),
    .mdio_in     (mdio_in)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic rd, input logic [4:0] phy,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, d};
  endfunction

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0;
      m_data = '0;
    end else if (m_busy != 0) begin
      if (!mgmt_en) begin
        m_busy = 0;
      end else begin
        if (m_rd != 0 && (m_t % m_n) == m_n / 2 - 1 && m_t / m_n >= 48)
          m_cap = {m_cap[14:0], mdio_in};
        m_t++;
        if (m_t == 64 * m_n) begin
          m_busy = 0;
          if (m_rd != 0) m_data[15:0] = m_cap;
        end
      end
    end else if (cmd_wr && mgmt_en) begin
      m_busy  = 1;
      m_t     = 0;
      m_n     = 8 << div_sel;
      m_rd    = cmd_word[29] ? 1 : 0;
      m_data  = cmd_word;
      m_frame = {32'hFFFF_FFFF, 2'b01, cmd_word[29] ? 2'b10 : 2'b01,
                 cmd_word[27:23], cmd_word[22:18], 2'b10, cmd_word[15:0]};
    end
  end

  // per-cycle comparison and PHY response, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      logic e_mdc;
      logic e_oe;
      int   b;
      b     = m_t / m_n;
      e_mdc = (m_busy != 0) && ((m_t % m_n) >= m_n / 2);
      e_oe  = (m_busy != 0) && !(m_rd != 0 && b >= 46);
      chk({31'd0, status_idle}, {31'd0, m_busy == 0}, "R4 idle");
      chk({31'd0, mdc}, {31'd0, e_mdc}, "R2 mdc");
      chk({31'd0, mdio_oe}, {31'd0, e_oe}, (m_rd != 0) ? "R7 oe" : "R6 oe");
      if (e_oe) chk({31'd0, mdio_out}, {31'd0, m_frame[63-b]}, "R5 R8 mdio_out");
      chk(data_word, m_data, "R3 R9 data_word");
      mdio_in = (m_busy != 0 && m_rd != 0 && b >= 48) ? resp[63-b] : 1'b1;
    end
  end

  task automatic issue(input logic [31:0] c, input logic [1:0] s);
    @(negedge clk);
    cmd_word = c;
    div_sel  = s;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!status_idle && n < 10000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({31'd0, status_idle}, 32'd1, "R1 idle");
    chk({31'd0, mdc}, 32'd0, "R1 mdc");
    chk({31'd0, mdio_oe}, 32'd0, "R1 oe");
    chk({31'd0, mdio_out}, 32'd0, "R1 out");
    chk(data_word, 32'd0, "R1 data");
    rst = 1'b0;
    mgmt_en = 1'b1;

    // R5 R6: write, ratio 8
    issue(mk(1'b0, 5'h11, 5'h04, 16'hA5C3), 2'd0);
    wait_idle();

    // R9 R3: read, ratio 16, with a second command while busy
    resp = 16'h3C96;
    c = mk(1'b1, 5'h1F, 5'h1A, 16'h0000);
    issue(c, 2'd1);
    repeat (200) @(negedge clk);
    issue(mk(1'b0, 5'h02, 5'h03, 16'h1234), 2'd0);
    chk(data_word, c, "R3 busy write ignored");
    wait_idle();
    chk(data_word, {c[31:16], 16'h3C96}, "R9 read result");

    // R2: ratio 32, div_sel changed mid-frame
    resp = 16'h8001;
    c = mk(1'b1, 5'h00, 5'h1F, 16'hFFFF);
    issue(c, 2'd2);
    repeat (300) @(negedge clk);
    div_sel = 2'd0;
    wait_idle();
    chk(data_word, {c[31:16], 16'h8001}, "R9 R2 read result");

    // R5: ratio 64, junk in start/opcode/turnaround positions
    c = mk(1'b0, 5'h15, 5'h0A, 16'h0001);
    c[31:30] = 2'b10;
    c[28]    = 1'b0;
    c[17:16] = 2'b01;
    issue(c, 2'd3);
    wait_idle();
    chk(data_word, c, "R5 write word kept");

    // R10: enable dropped mid-frame
    c = mk(1'b0, 5'h07, 5'h09, 16'h5A5A);
    issue(c, 2'd0);
    repeat (100) @(negedge clk);
    mgmt_en = 1'b0;
    @(negedge clk);
    chk({31'd0, mdc}, 32'd0, "R10 mdc stopped");
    chk({31'd0, status_idle}, 32'd1, "R10 idle");
    chk(data_word, c, "R10 data kept");

    // R11: command while disabled
    issue(mk(1'b1, 5'h01, 5'h01, 16'h0000), 2'd0);
    @(negedge clk);
    chk({31'd0, status_idle}, 32'd1, "R11 no start");
    chk(data_word, c, "R11 data unchanged");
    mgmt_en = 1'b1;

    // back-to-back read then write, ratio 8
    resp = 16'h0000;
    c = mk(1'b1, 5'h1E, 5'h01, 16'h0000);
    issue(c, 2'd0);
    wait_idle();
    chk(data_word, {c[31:16], 16'h0000}, "R9 zero read");
    issue(mk(1'b0, 5'h1E, 5'h01, 16'hFFFF), 2'd0);
    wait_idle();
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule